// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide internal form (a class code, a sign, an unbiased exponent, a 26-bit mantissa with two extra low bits and a separate sticky bit) and produces the final 32-bit single-precision word. Along the way it applies the selected rounding mode. It denormalises results that fall below the normal range and promotes a subnormal that rounds up into the smallest normal. It saturates or goes to infinity on overflow, depending on mode and sign. It also raises the overflow, underflow and inexact flags.

It sits at the back end of an arithmetic datapath. The producer presents one value per cycle with `valid_i`. The packed word and flags come out registered one cycle later with `valid_o`. The mantissa carries its leading one at bit 25, the 23 fraction bits at 24:2, and the guard and round bits at 1:0. The output word is sign[31], biased exponent[30:23] and fraction[22:0].

Top module: `sp_packer`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. Word and flags update one cycle after an accepted input and hold otherwise. After reset, `valid_o`, `word_o` and all flags are 0.
- R2: The class code is 0 = zero, 1 = number, 2 = infinity, 3 = NaN. Zero packs to the sign bit alone. Infinity packs to the sign bit, exponent 0xFF and fraction 0. Neither raises a flag.
- R3: A NaN packs to exponent 0xFF with fraction {1, mant[23:2]}, so the quiet bit 22 is always set. It is not rounded and raises no flag.
- R4: For a number, the biased exponent is the exponent plus 127. When the biased exponent is at least 1 and no rounding or overflow applies, the word is {sign, biased, mant[24:2]} and no flag is raised.
- R5: The rounding mode is 0 = nearest-even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf. Inexact is set when guard, round or sticky is set. Under nearest-even the value rounds up when guard is set and any of round, sticky or the kept LSB is set. Toward +inf rounds up an inexact positive value. Toward -inf rounds up an inexact negative value.
- R6: When a rounding carry makes the significand 2.0, the exponent is incremented and the fraction is 0.
- R7: A biased exponent of 255 or more after rounding raises overflow and inexact. The result is infinity under nearest-even, under toward +inf when positive, and under toward -inf when negative. In every other case it is exponent 254 with an all-ones fraction.
- R8: A biased exponent of 0 or less shifts the mantissa right by (1 - biased) extra places before rounding. Bits shifted out fold into sticky. The exponent field is 0.
- R9: A subnormal result raises underflow when it is inexact or when `uf_trap_en_i` is set.
- R10: A subnormal that rounds up to the weight of exponent 1 packs to {sign, exponent 1, fraction 0}. It raises inexact but not underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value present |
| class_i | input | 2 | Class code (R2) |
| sign_i | input | 1 | Sign, 1 = negative |
| exp_i | input | 10 | Unbiased exponent, two's complement |
| mant_i | input | 26 | Mantissa: leading one at 25, guard/round at 1:0 |
| sticky_i | input | 1 | OR of bits below the round bit |
| rmode_i | input | 2 | Rounding mode (R5) |
| uf_trap_en_i | input | 1 | Underflow trap enable |
| valid_o | output | 1 | Output word present |
| word_o | output | 32 | Packed single-precision word |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |

## Verification
The bench targets a round-to-nearest tie with an even and with an odd LSB. A design that always rounds half up, or that ignores the LSB, returns a wrong fraction there. It drives an all-ones mantissa into both the normal and the subnormal path. A design that drops the carry fails to step the exponent or to promote to the smallest normal, and one that flags underflow on promotion raises a spurious flag. Overflow is driven in all four modes and both signs, which catches a design that swaps the saturation direction. Deep subnormal shifts check that bits shifted out still reach sticky, which decides whether the result rounds to zero or to the smallest subnormal.

// File: rtl/sp_packer_pkg.sv
`timescale 1ns/1ps
package sp_packer_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_PINF = 2'd2,
    RM_NINF = 2'd3
  } rmode_e;
endpackage

// File: rtl/spk_denorm.sv
`timescale 1ns/1ps
// Right shift with lost-bit collection for the subnormal path.
module spk_denorm #(
  parameter int W    = 26,
  parameter int SH_W = 5
) (
  input  logic [W-1:0]    m_i,
  input  logic [SH_W-1:0] sh_i,
  output logic [W-1:0]    m_o,
  output logic            lost_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask   = ~({W{1'b1}} << sh_i);
    m_o    = m_i >> sh_i;
    lost_o = |(m_i & mask);
  end
endmodule

// File: rtl/spk_round.sv
`timescale 1ns/1ps
// Drops guard/round, decides increment, returns significand with carry bit.
module spk_round
  import sp_packer_pkg::*;
#(
  parameter int W = 26
) (
  input  logic [W-1:0] m_i,
  input  logic         sticky_i,
  input  logic         sign_i,
  input  rmode_e       rmode_i,
  output logic [W-2:0] sig_o,
  output logic         inexact_o
);
  logic [W-3:0] trunc;
  logic         g, r, up;

  always_comb begin
    trunc     = m_i[W-1:2];
    g         = m_i[1];
    r         = m_i[0];
    inexact_o = g | r | sticky_i;
    unique case (rmode_i)
      RM_NEAR: up = g & (r | sticky_i | trunc[0]);
      RM_ZERO: up = 1'b0;
      RM_PINF: up = inexact_o & ~sign_i;
      RM_NINF: up = inexact_o & sign_i;
      default: up = 1'b0;
    endcase
    sig_o = {1'b0, trunc} + (W-1)'(up);
  end
endmodule

// File: rtl/spk_ovf_sel.sv
`timescale 1ns/1ps
// Overflow result: infinity or largest finite, by mode and sign.
module spk_ovf_sel
  import sp_packer_pkg::*;
#(
  parameter int EXPF_W = 8,
  parameter int FRAC_W = 23
) (
  input  logic                       sign_i,
  input  rmode_e                     rmode_i,
  output logic [EXPF_W+FRAC_W:0]     word_o
);
  logic to_inf;

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: to_inf = 1'b1;
      RM_ZERO: to_inf = 1'b0;
      RM_PINF: to_inf = ~sign_i;
      RM_NINF: to_inf = sign_i;
      default: to_inf = 1'b1;
    endcase
    if (to_inf) word_o = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
    else        word_o = {sign_i, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  end
endmodule

// File: rtl/sp_packer.sv
`timescale 1ns/1ps
module sp_packer
  import sp_packer_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int FRAC_W = 23,
  parameter int EXPF_W = 8,
  parameter int MANT_W = FRAC_W + 3,
  parameter int WORD_W = 1 + EXPF_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        class_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        rmode_i,
  input  logic              uf_trap_en_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              of_o,
  output logic              uf_o,
  output logic              nx_o
);
  localparam int EW       = EXP_W + 2;
  localparam int BIAS     = (1 << (EXPF_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXPF_W) - 1;
  localparam int SH_MAX   = MANT_W + 1;
  localparam int SH_W     = $clog2(SH_MAX + 1);

  rmode_e            rm;
  fp_cls_e           cls;
  logic [EW-1:0]     biased, sh_full, exp_n;
  logic              sub, ovf;
  logic [SH_W-1:0]   sh;
  logic [MANT_W-1:0] dn_m, rnd_m;
  logic              dn_lost, rnd_s, rnd_nx;
  logic [MANT_W-2:0] sig;
  logic [WORD_W-1:0] ovf_word, word_d;
  logic              of_d, uf_d, nx_d;

  assign rm  = rmode_e'(rmode_i);
  assign cls = fp_cls_e'(class_i);

  always_comb begin
    biased  = {{2{exp_i[EXP_W-1]}}, exp_i} + EW'(BIAS);
    sub     = biased[EW-1] | (biased == '0);
    sh_full = EW'(1) - biased;
    sh      = (sh_full >= EW'(SH_MAX)) ? SH_W'(SH_MAX) : sh_full[SH_W-1:0];
    if (!sub) sh = '0;
  end

  spk_denorm #(.W(MANT_W), .SH_W(SH_W)) u_denorm (
    .m_i    (mant_i),
    .sh_i   (sh),
    .m_o    (dn_m),
    .lost_o (dn_lost)
  );

  assign rnd_m = sub ? dn_m : mant_i;
  assign rnd_s = sticky_i | (sub & dn_lost);

  spk_round #(.W(MANT_W)) u_round (
    .m_i       (rnd_m),
    .sticky_i  (rnd_s),
    .sign_i    (sign_i),
    .rmode_i   (rm),
    .sig_o     (sig),
    .inexact_o (rnd_nx)
  );

  spk_ovf_sel #(.EXPF_W(EXPF_W), .FRAC_W(FRAC_W)) u_ovf (
    .sign_i  (sign_i),
    .rmode_i (rm),
    .word_o  (ovf_word)
  );

  assign exp_n = biased + EW'(sig[MANT_W-2]);
  assign ovf   = ~exp_n[EW-1] & (exp_n >= EW'(EXP_ALL1));

  always_comb begin
    word_d = '0;
    of_d   = 1'b0;
    uf_d   = 1'b0;
    nx_d   = 1'b0;
    unique case (cls)
      CLS_ZERO: word_d = {sign_i, {(WORD_W-1){1'b0}}};
      CLS_INF:  word_d = {sign_i, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NAN:  word_d = {sign_i, {EXPF_W{1'b1}}, 1'b1, mant_i[FRAC_W:2]};
      default: begin
        nx_d = rnd_nx;
        if (sub) begin
          // sig[FRAC_W] set only when a rounding carry reached exponent 1
          word_d = {sign_i, {(EXPF_W-1){1'b0}}, sig[FRAC_W], sig[FRAC_W-1:0]};
          uf_d   = ~sig[FRAC_W] & (rnd_nx | uf_trap_en_i);
        end else if (ovf) begin
          word_d = ovf_word;
          of_d   = 1'b1;
          nx_d   = 1'b1;
        end else begin
          word_d = {sign_i, exp_n[EXPF_W-1:0], sig[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      of_o    <= 1'b0;
      uf_o    <= 1'b0;
      nx_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o <= word_d;
        of_o   <= of_d;
        uf_o   <= uf_d;
        nx_o   <= nx_d;
      end
    end
  end

  // R1
  vld_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R7
  ovf_nx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> nx_o);

  // R7
  ovf_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_o |-> (word_o[WORD_W-2:FRAC_W] >= EXPF_W'(EXP_ALL1 - 1)));

  // R9
  uf_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o |-> (word_o[WORD_W-2:FRAC_W] == '0));

  // R3
  nan_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (word_o[WORD_W-2:FRAC_W] == EXPF_W'(EXP_ALL1)) &&
     (word_o[FRAC_W-1:0] != '0)) |-> word_o[FRAC_W-1]);

  // R9
  uf_of_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(uf_o && of_o));
endmodule

// File: tb/sp_packer_tb_top.sv
`timescale 1ns/1ps
module sp_packer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  class_i = '0;
  logic        sign_i = 1'b0;
  logic [9:0]  exp_i = '0;
  logic [25:0] mant_i = '0;
  logic        sticky_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic        uf_trap_en_i = 1'b0;
  logic        valid_o;
  logic [31:0] word_o;
  logic        of_o, uf_o, nx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [25:0] ONE  = 26'h2000000;
  localparam logic [25:0] ALL1 = 26'h3FFFFFF;

  always #2.5 clk_i = ~clk_i;

  sp_packer dut_i (
    .clk_i, .rst_ni, .valid_i, .class_i, .sign_i, .exp_i, .mant_i,
    .sticky_i, .rmode_i, .uf_trap_en_i, .valid_o, .word_o, .of_o, .uf_o, .nx_o
  );

  task automatic chk(input string req, input logic [31:0] w,
                     input logic of, input logic uf, input logic nx);
    n_chk++;
    if (valid_o !== 1'b1 || word_o !== w || of_o !== of || uf_o !== uf || nx_o !== nx) begin
      n_fail++;
      $display("FAIL %s: got v=%b w=%h of=%b uf=%b nx=%b exp v=1 w=%h of=%b uf=%b nx=%b",
               req, valid_o, word_o, of_o, uf_o, nx_o, w, of, uf, nx);
    end
  endtask

  task automatic put(input logic [1:0] c, input logic s, input int e,
                     input logic [25:0] m, input logic st, input logic [1:0] rm,
                     input logic te);
    @(negedge clk_i);
    valid_i = 1'b1; class_i = c; sign_i = s; exp_i = 10'(e);
    mant_i = m; sticky_i = st; rmode_i = rm; uf_trap_en_i = te;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    n_chk++;
    if (valid_o !== 1'b0 || word_o !== 32'h0 || of_o | uf_o | nx_o) begin
      n_fail++;
      $display("FAIL R1 reset: got v=%b w=%h exp v=0 w=0", valid_o, word_o);
    end
  endtask

  task automatic t_valid_delay;
    put(2'd1, 0, 0, ONE, 0, 0, 0);
    chk("R1 one-cycle valid", 32'h3F800000, 0, 0, 0);
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || word_o !== 32'h3F800000) begin
      n_fail++;
      $display("FAIL R1 hold: got v=%b w=%h exp v=0 w=3f800000", valid_o, word_o);
    end
  endtask

  task automatic t_specials;
    put(2'd0, 1, 5, ALL1, 1, 0, 1); chk("R2 zero", 32'h80000000, 0, 0, 0);
    put(2'd2, 0, 0, ALL1, 1, 1, 0); chk("R2 inf", 32'h7F800000, 0, 0, 0);
    put(2'd3, 0, 0, ONE | 26'h4 | 26'h3, 1, 0, 0); chk("R3 nan", 32'h7FC00001, 0, 0, 0);
  endtask

  task automatic t_normal;
    put(2'd1, 0, 0, ONE, 0, 0, 0);  chk("R4 exact 1.0", 32'h3F800000, 0, 0, 0);
    put(2'd1, 1, -126, ONE | 26'h8, 0, 1, 0); chk("R4 min normal", 32'h80800002, 0, 0, 0);
  endtask

  task automatic t_round;
    put(2'd1, 0, 0, ONE | 26'h2, 0, 0, 0);        chk("R5 tie even down", 32'h3F800000, 0, 0, 1);
    put(2'd1, 0, 0, ONE | 26'h6, 0, 0, 0);        chk("R5 tie odd up", 32'h3F800002, 0, 0, 1);
    put(2'd1, 0, 0, ONE | 26'h2, 1, 0, 0);        chk("R5 above tie", 32'h3F800001, 0, 0, 1);
    put(2'd1, 0, 0, ONE | 26'h3, 0, 1, 0);        chk("R5 to zero", 32'h3F800000, 0, 0, 1);
    put(2'd1, 0, 0, ONE | 26'h1, 0, 2, 0);        chk("R5 pinf pos", 32'h3F800001, 0, 0, 1);
    put(2'd1, 1, 0, ONE | 26'h1, 0, 2, 0);        chk("R5 pinf neg", 32'hBF800000, 0, 0, 1);
    put(2'd1, 1, 0, ONE, 1, 3, 0);                chk("R5 ninf neg", 32'hBF800001, 0, 0, 1);
  endtask

  task automatic t_carry;
    put(2'd1, 0, 0, ALL1, 0, 0, 0); chk("R6 carry exp", 32'h40000000, 0, 0, 1);
  endtask

  task automatic t_overflow;
    put(2'd1, 0, 127, ALL1, 0, 0, 0); chk("R7 near inf", 32'h7F800000, 1, 0, 1);
    put(2'd1, 0, 127, ALL1, 0, 1, 0); chk("R7 zero no-round", 32'h7F7FFFFF, 0, 0, 1);
    put(2'd1, 0, 128, ONE, 0, 1, 0);  chk("R7 zero max", 32'h7F7FFFFF, 1, 0, 1);
    put(2'd1, 1, 200, ONE, 0, 2, 0);  chk("R7 pinf neg max", 32'hFF7FFFFF, 1, 0, 1);
    put(2'd1, 1, 200, ONE, 0, 3, 0);  chk("R7 ninf neg inf", 32'hFF800000, 1, 0, 1);
    put(2'd1, 0, 200, ONE, 0, 3, 0);  chk("R7 ninf pos max", 32'h7F7FFFFF, 1, 0, 1);
  endtask

  task automatic t_subnormal;
    put(2'd1, 0, -127, ONE, 0, 0, 0);        chk("R8 shift1 exact", 32'h00400000, 0, 0, 0);
    put(2'd1, 0, -127, ONE, 0, 0, 1);        chk("R9 trap exact", 32'h00400000, 0, 1, 0);
    put(2'd1, 0, -149, ONE, 0, 0, 0);        chk("R8 min subnormal", 32'h00000001, 0, 0, 0);
    put(2'd1, 0, -150, ONE, 0, 0, 0);        chk("R9 tie to zero", 32'h00000000, 0, 1, 1);
    put(2'd1, 1, -150, ONE | 26'h1, 0, 0, 0); chk("R8 lost bits sticky", 32'h80000001, 0, 1, 1);
    put(2'd1, 0, -300, ONE, 0, 2, 0);        chk("R8 deep shift", 32'h00000001, 0, 1, 1);
  endtask

  task automatic t_promote;
    put(2'd1, 0, -127, ALL1, 0, 0, 0); chk("R10 promote", 32'h00800000, 0, 0, 1);
    put(2'd1, 1, -127, ALL1, 0, 0, 1); chk("R10 promote trap", 32'h80800000, 0, 0, 1);
    put(2'd1, 0, -127, ALL1, 0, 1, 0); chk("R10 no promote", 32'h007FFFFF, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_valid_delay();
    t_specials();
    t_normal();
    t_round();
    t_carry();
    t_overflow();
    t_subnormal();
    t_promote();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule